// File: doc/BRIEF.md
# Guest Event Exit Filter

This block sits between the event sources of a virtualised core and its exit sequencer. Each incoming guest event is classified as an exception carrying a vector, an NMI, an external interrupt, a startup IPI or an INIT. The block then decides whether that event forces a direct exit to the host. The decision uses a 32-entry exception bitmap, three exit controls and the current activity state of the core. Events that do not exit are handed on to the normal delivery path.

When an event exits, the block raises an exit request and holds it until the exit sequencer reports completion. For the whole of that window it marks the exit as one whose architectural side effects must be suppressed: no fault-address update, no debug-status update and no last-exception record. An external interrupt is acknowledged to the interrupt controller only when the acknowledge control is set; otherwise it stays pending. Two effects are held back until completion has been reported: blocking of further NMIs after an NMI exit, and the return to the active state when the core was idle.

Top module: `guest_exit_filter`

## Requirements
- R1: An exception (event code 0) exits directly when bit `evt_vector` of `exc_bitmap` is 1. Otherwise it is delivered.
- R2: An NMI (event code 1) exits directly when `ctl_nmi_exit` is 1. Otherwise it is delivered.
- R3: An external interrupt (event code 2) exits directly when `ctl_extint_exit` is 1. Otherwise it is delivered.
- R4: A startup IPI (event code 3) exits directly only when `act_state` is 3 (waiting for startup). An INIT (event code 4) exits directly only when `act_state` is not 3. In every other case these events are delivered.
- R5: `nmi_block_set` pulses for exactly one cycle, in the cycle after `exit_done` is sampled during an NMI exit. It stays low at all other times.
- R6: `intc_ack` pulses for one cycle, in the cycle after acceptance, only for a directly exiting external interrupt while `ctl_ack_on_exit` is 1. If the control is 0, no acknowledge is given and the interrupt is left pending.
- R7: `suppress_arch` is high from the cycle after a directly exiting event is accepted until the cycle after `exit_done`. It is low at all other times.
- R8: `wake_active` pulses for one cycle after `exit_done` is sampled, but only when `act_state` was non-zero (not active) when the exiting event was accepted. It is never raised before completion.
- R9: A delivered event appears on `dlv_valid`/`dlv_type`/`dlv_vector` in the cycle after acceptance. It is held stable until `dlv_ready` is sampled high. `evt_ready` is low while an exit is pending, and also while an undelivered event is held and `dlv_ready` is low.
- R10: `exit_req` rises in the cycle after a directly exiting event is accepted and stays high until `exit_done` is sampled. While it is high, `exit_type`/`exit_vector` report the accepted event.
- R11: After reset, `exit_req`, `suppress_arch`, `intc_ack`, `nmi_block_set`, `wake_active` and `dlv_valid` are 0, and `evt_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Incoming event present |
| evt_ready | output | 1 | Block can accept an event this cycle |
| evt_type | input | 3 | Event code: 0 exception, 1 NMI, 2 external interrupt, 3 startup IPI, 4 INIT |
| evt_vector | input | 5 | Exception vector (bitmap index) |
| exc_bitmap | input | 32 | One exit bit per exception vector |
| ctl_nmi_exit | input | 1 | NMIs exit directly |
| ctl_extint_exit | input | 1 | External interrupts exit directly |
| ctl_ack_on_exit | input | 1 | Acknowledge an exiting external interrupt |
| act_state | input | 2 | 0 active, 1 halted, 2 shut down, 3 waiting for startup |
| exit_done | input | 1 | Exit sequencer has finished the exit |
| exit_req | output | 1 | Direct exit in progress |
| exit_type | output | 3 | Code of the exiting event |
| exit_vector | output | 5 | Vector of the exiting event |
| suppress_arch | output | 1 | Suppress architectural side effects of the event |
| intc_ack | output | 1 | Acknowledge pulse to the interrupt controller |
| nmi_block_set | output | 1 | Start blocking NMIs (after completion) |
| wake_active | output | 1 | Return to active state (after completion) |
| dlv_valid | output | 1 | Non-exiting event offered for delivery |
| dlv_ready | input | 1 | Delivery path accepts the event |
| dlv_type | output | 3 | Code of the delivered event |
| dlv_vector | output | 5 | Vector of the delivered event |

## Verification
Every classification decision shows on the ports one cycle after acceptance. A wrong bitmap index, control selection or activity-state test therefore appears immediately as `exit_req` and `dlv_valid` being swapped. Faults in the completion state — the remembered NMI flag or the remembered idle flag — do not show until the cycle after `exit_done`. At that point a missing or spurious `nmi_block_set`/`wake_active` pulse exposes them. Such a fault can stay hidden for as many cycles as the exit takes, so the stimulus varies that delay. A stuck delivery slot shows as `evt_ready` staying low, or as the offered event changing before `dlv_ready` is sampled.

// File: rtl/gef_pkg.sv
package gef_pkg;

    typedef enum logic [2:0] {
        EV_EXC  = 3'd0,
        EV_NMI  = 3'd1,
        EV_EXT  = 3'd2,
        EV_SIPI = 3'd3,
        EV_INIT = 3'd4
    } ev_kind_e;

    localparam logic [1:0] ACT_RUN       = 2'd0;
    localparam logic [1:0] ACT_WAIT_SIPI = 2'd3;

endpackage

// File: rtl/gef_bit_pick.sv
module gef_bit_pick #(
    parameter int SEL_W = 5,
    localparam int MAP_W = 1 << SEL_W
) (
    input  logic [MAP_W-1:0] map_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             bit_o
);
    logic [MAP_W-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < MAP_W; gi++) begin : g_dec
            assign hit[gi] = map_i[gi] && (sel_i == SEL_W'(gi));
        end
    endgenerate

    assign bit_o = |hit;
endmodule

// File: rtl/gef_decide.sv
module gef_decide
    import gef_pkg::*;
(
    input  logic [2:0] kind_i,
    input  logic       map_bit_i,
    input  logic       nmi_exit_i,
    input  logic       ext_exit_i,
    input  logic       ack_ctl_i,
    input  logic [1:0] state_i,
    output logic       direct_o,
    output logic       is_nmi_o,
    output logic       ack_o
);
    always_comb begin
        direct_o = 1'b0;
        unique case (kind_i)
            EV_EXC:  direct_o = map_bit_i;
            EV_NMI:  direct_o = nmi_exit_i;
            EV_EXT:  direct_o = ext_exit_i;
            EV_SIPI: direct_o = (state_i == ACT_WAIT_SIPI);
            EV_INIT: direct_o = (state_i != ACT_WAIT_SIPI);
            default: direct_o = 1'b0;
        endcase
        is_nmi_o = direct_o && (kind_i == EV_NMI);
        ack_o    = direct_o && (kind_i == EV_EXT) && ack_ctl_i;
    end
endmodule

// File: rtl/guest_exit_filter.sv
module guest_exit_filter
    import gef_pkg::*;
#(
    parameter int VEC_W = 5,
    localparam int MAP_W = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    output logic             evt_ready,
    input  logic [2:0]       evt_type,
    input  logic [VEC_W-1:0] evt_vector,
    input  logic [MAP_W-1:0] exc_bitmap,
    input  logic             ctl_nmi_exit,
    input  logic             ctl_extint_exit,
    input  logic             ctl_ack_on_exit,
    input  logic [1:0]       act_state,
    input  logic             exit_done,
    output logic             exit_req,
    output logic [2:0]       exit_type,
    output logic [VEC_W-1:0] exit_vector,
    output logic             suppress_arch,
    output logic             intc_ack,
    output logic             nmi_block_set,
    output logic             wake_active,
    output logic             dlv_valid,
    input  logic             dlv_ready,
    output logic [2:0]       dlv_type,
    output logic [VEC_W-1:0] dlv_vector
);
    typedef struct packed {
        logic             exit_req;
        logic             suppress;
        logic [2:0]       x_kind;
        logic [VEC_W-1:0] x_vec;
        logic             nmi_pend;
        logic             wake_pend;
        logic             ack;
        logic             nmi_blk;
        logic             wake;
        logic             dlv_valid;
        logic [2:0]       d_kind;
        logic [VEC_W-1:0] d_vec;
    } st_t;

    st_t st_d, st_q;

    logic map_bit, direct, is_nmi, need_ack, accept;

    gef_bit_pick #(.SEL_W(VEC_W)) u_pick (
        .map_i (exc_bitmap),
        .sel_i (evt_vector),
        .bit_o (map_bit)
    );

    gef_decide u_decide (
        .kind_i     (evt_type),
        .map_bit_i  (map_bit),
        .nmi_exit_i (ctl_nmi_exit),
        .ext_exit_i (ctl_extint_exit),
        .ack_ctl_i  (ctl_ack_on_exit),
        .state_i    (act_state),
        .direct_o   (direct),
        .is_nmi_o   (is_nmi),
        .ack_o      (need_ack)
    );

    assign evt_ready = !st_q.exit_req && (!st_q.dlv_valid || dlv_ready);
    assign accept    = evt_valid && evt_ready;

    always_comb begin
        st_d         = st_q;
        st_d.ack     = 1'b0;
        st_d.nmi_blk = 1'b0;
        st_d.wake    = 1'b0;

        if (st_q.dlv_valid && dlv_ready) begin
            st_d.dlv_valid = 1'b0;
        end

        if (st_q.exit_req && exit_done) begin
            st_d.exit_req  = 1'b0;
            st_d.suppress  = 1'b0;
            st_d.nmi_blk   = st_q.nmi_pend;
            st_d.wake      = st_q.wake_pend;
            st_d.nmi_pend  = 1'b0;
            st_d.wake_pend = 1'b0;
        end

        if (accept) begin
            if (direct) begin
                st_d.exit_req  = 1'b1;
                st_d.suppress  = 1'b1;
                st_d.x_kind    = evt_type;
                st_d.x_vec     = evt_vector;
                st_d.nmi_pend  = is_nmi;
                st_d.wake_pend = (act_state != ACT_RUN);
                st_d.ack       = need_ack;
            end else begin
                st_d.dlv_valid = 1'b1;
                st_d.d_kind    = evt_type;
                st_d.d_vec     = evt_vector;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exit_req      = st_q.exit_req;
    assign exit_type     = st_q.x_kind;
    assign exit_vector   = st_q.x_vec;
    assign suppress_arch = st_q.suppress;
    assign intc_ack      = st_q.ack;
    assign nmi_block_set = st_q.nmi_blk;
    assign wake_active   = st_q.wake;
    assign dlv_valid     = st_q.dlv_valid;
    assign dlv_type      = st_q.d_kind;
    assign dlv_vector    = st_q.d_vec;
endmodule

// File: rtl/guest_exit_filter_chk.sv
module guest_exit_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_valid,
    input logic       evt_ready,
    input logic [2:0] evt_type,
    input logic       ctl_ack_on_exit,
    input logic       exit_done,
    input logic       exit_req,
    input logic [2:0] exit_type,
    input logic       suppress_arch,
    input logic       intc_ack,
    input logic       nmi_block_set,
    input logic       wake_active,
    input logic       dlv_valid,
    input logic       dlv_ready,
    input logic [2:0] dlv_type
);
    AST_EXIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req && !exit_done |=> exit_req && $stable(exit_type)); // R10

    AST_EXIT_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exit_req) |-> $past(evt_valid && evt_ready)); // R10

    AST_NMI_BLOCK_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_block_set |-> $past(exit_req && exit_done && exit_type == 3'd1)); // R5

    AST_WAKE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_active |-> $past(exit_req && exit_done)); // R8

    AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        intc_ack |-> $past(evt_valid && evt_ready && evt_type == 3'd2 && ctl_ack_on_exit)); // R6

    AST_SUPPRESS_WITH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suppress_arch) |-> $rose(exit_req)); // R7

    AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_type)); // R9

    AST_NO_ACCEPT_IN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> !evt_ready); // R9
endmodule

bind guest_exit_filter guest_exit_filter_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_valid       (evt_valid),
    .evt_ready       (evt_ready),
    .evt_type        (evt_type),
    .ctl_ack_on_exit (ctl_ack_on_exit),
    .exit_done       (exit_done),
    .exit_req        (exit_req),
    .exit_type       (exit_type),
    .suppress_arch   (suppress_arch),
    .intc_ack        (intc_ack),
    .nmi_block_set   (nmi_block_set),
    .wake_active     (wake_active),
    .dlv_valid       (dlv_valid),
    .dlv_ready       (dlv_ready),
    .dlv_type        (dlv_type)
);

// File: tb/guest_exit_filter_tb.sv
`timescale 1ns/1ps
module guest_exit_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [2:0]  evt_type = '0;
    logic [4:0]  evt_vector = '0;
    logic [31:0] exc_bitmap = '0;
    logic        ctl_nmi_exit = 1'b0;
    logic        ctl_extint_exit = 1'b0;
    logic        ctl_ack_on_exit = 1'b0;
    logic [1:0]  act_state = '0;
    logic        exit_done = 1'b0;
    logic        exit_req;
    logic [2:0]  exit_type;
    logic [4:0]  exit_vector;
    logic        suppress_arch;
    logic        intc_ack;
    logic        nmi_block_set;
    logic        wake_active;
    logic        dlv_valid;
    logic        dlv_ready = 1'b1;
    logic [2:0]  dlv_type;
    logic [4:0]  dlv_vector;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    guest_exit_filter dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_type(evt_type), .evt_vector(evt_vector), .exc_bitmap(exc_bitmap),
        .ctl_nmi_exit(ctl_nmi_exit), .ctl_extint_exit(ctl_extint_exit),
        .ctl_ack_on_exit(ctl_ack_on_exit), .act_state(act_state),
        .exit_done(exit_done), .exit_req(exit_req), .exit_type(exit_type),
        .exit_vector(exit_vector), .suppress_arch(suppress_arch),
        .intc_ack(intc_ack), .nmi_block_set(nmi_block_set),
        .wake_active(wake_active), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
        .dlv_type(dlv_type), .dlv_vector(dlv_vector)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_exit(input logic [2:0] k, input logic [4:0] v,
                                    input logic [31:0] m, input bit nmi_c,
                                    input bit ext_c, input logic [1:0] st);
        case (k)
            3'd0:    return m[v];
            3'd1:    return nmi_c;
            3'd2:    return ext_c;
            3'd3:    return st == 2'd3;
            3'd4:    return st != 2'd3;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd0:    return "R1";
            3'd1:    return "R2";
            3'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic run_event(input logic [2:0] k, input logic [4:0] v,
                             input logic [31:0] m, input bit nmi_c, input bit ext_c,
                             input bit ack_c, input logic [1:0] st, input int dly);
        bit ex;
        ex = exp_exit(k, v, m, nmi_c, ext_c, st);
        @(negedge clk);
        evt_type = k; evt_vector = v; exc_bitmap = m;
        ctl_nmi_exit = nmi_c; ctl_extint_exit = ext_c; ctl_ack_on_exit = ack_c;
        act_state = st; evt_valid = 1'b1;
        chk("R9", "evt_ready idle", evt_ready, 1);
        @(negedge clk);
        evt_valid = 1'b0;
        chk(tag_of(k), "exit_req", exit_req, ex);
        chk(tag_of(k), "dlv_valid", dlv_valid, !ex);
        chk("R7", "suppress_arch", suppress_arch, ex);
        chk("R6", "intc_ack", intc_ack, ex && k == 3'd2 && ack_c);
        if (ex) begin
            chk("R10", "exit_type", exit_type, k);
            chk("R10", "exit_vector", exit_vector, v);
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk("R10", "exit_req held", exit_req, 1);
                chk("R5", "nmi_block early", nmi_block_set, 0);
                chk("R8", "wake early", wake_active, 0);
                chk("R6", "ack single", intc_ack, 0);
            end
            exit_done = 1'b1;
            @(negedge clk);
            exit_done = 1'b0;
            chk("R10", "exit_req drop", exit_req, 0);
            chk("R7", "suppress drop", suppress_arch, 0);
            chk("R5", "nmi_block_set", nmi_block_set, k == 3'd1);
            chk("R8", "wake_active", wake_active, st != 2'd0);
            @(negedge clk);
            chk("R5", "nmi_block pulse end", nmi_block_set, 0);
            chk("R8", "wake pulse end", wake_active, 0);
        end else begin
            chk("R9", "dlv_type", dlv_type, k);
            chk("R9", "dlv_vector", dlv_vector, v);
            chk("R8", "no wake", wake_active, 0);
            @(negedge clk);
            chk("R9", "dlv consumed", dlv_valid, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "exit_req", exit_req, 0);
        chk("R11", "dlv_valid", dlv_valid, 0);
        chk("R11", "intc_ack", intc_ack, 0);
        chk("R11", "nmi_block_set", nmi_block_set, 0);
        chk("R11", "wake_active", wake_active, 0);
        chk("R11", "suppress_arch", suppress_arch, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "evt_ready", evt_ready, 1);

        // Directed corners
        run_event(3'd0, 5'd31, 32'h8000_0000, 0, 0, 0, 2'd0, 0);   // R1 top bit
        run_event(3'd0, 5'd0, 32'hFFFF_FFFE, 0, 0, 0, 2'd0, 1);    // R1 bit clear
        run_event(3'd1, 5'd2, 32'h0, 1, 0, 0, 2'd1, 3);            // R2 R5 R8
        run_event(3'd1, 5'd2, 32'h0, 0, 1, 1, 2'd0, 0);            // R2 delivered
        run_event(3'd2, 5'd0, 32'h0, 0, 1, 1, 2'd0, 2);            // R3 R6 ack
        run_event(3'd2, 5'd0, 32'h0, 0, 1, 0, 2'd0, 2);            // R6 left pending
        run_event(3'd3, 5'd0, 32'h0, 0, 0, 0, 2'd3, 1);            // R4 SIPI exits
        run_event(3'd3, 5'd0, 32'h0, 0, 0, 0, 2'd1, 0);            // R4 SIPI delivered
        run_event(3'd4, 5'd0, 32'h0, 0, 0, 0, 2'd3, 0);            // R4 INIT delivered
        run_event(3'd4, 5'd0, 32'h0, 0, 0, 0, 2'd2, 4);            // R4 INIT exits

        // R9 delivery hold under back-pressure
        dlv_ready = 1'b0;
        @(negedge clk);
        evt_type = 3'd0; evt_vector = 5'd7; exc_bitmap = 32'h0; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        chk("R9", "held valid", dlv_valid, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9", "still held", dlv_valid, 1);
            chk("R9", "held vector", dlv_vector, 5'd7);
            chk("R9", "ready low when full", evt_ready, 0);
        end
        dlv_ready = 1'b1;
        #0;
        chk("R9", "ready passes through", evt_ready, 1);
        @(negedge clk);
        chk("R9", "drained", dlv_valid, 0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0] k;
            k = 3'($urandom_range(0, 4));
            run_event(k, 5'($urandom), $urandom, 1'($urandom), 1'($urandom),
                      1'($urandom), 2'($urandom), int'($urandom_range(0, 3)));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule